// File: doc/BRIEF.md
# Start-Bit Framed Seven-Segment Frame Receiver

This block takes a one-way serial stream meant for a three-digit seven-segment display and keeps the decoded result in output registers. The host drives three lines: a serial clock, a serial data line and an active-low enable. A frame begins with a '1' start bit. Next come the payload bits, and then one more clock. No separate load strobe exists. The receiver knows a frame is complete when the start bit reaches the far end of its shift register. At that point it copies the payload to the outputs and clears itself, so it is ready for the next start bit.

All logic runs on one system clock. The serial clock, data and enable pass through a multi-stage synchroniser. A serial clock rising edge is detected in the system domain, and that edge advances the shift register. When enable is high, the bit shifted in is forced to '0'. Enable never resets the register. After a frame, extra clocks that carry '0' have no effect. The next '1' starts a new frame.

The digit count, the number of extra output pins and the synchroniser depth are parameters. With the defaults a frame is 36 serial clocks: one start bit, 34 payload bits and one latch clock.

Top module: `seg_frame_rx`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is low, `digit_o` and `pins_o` are all zero, and the shift register is cleared.
- R2: A frame is a '1' start bit, then 34 payload bits with the most significant first, then one more clock. That final clock moves the payload to the outputs. The 34-bit payload word P maps as {pins_o, digit_o}. Digit k sits at digit_o[8k+7:8k], with bit 7 the decimal point and bits 6..0 the segments g, f, e, d, c, b, a. So the first payload bit is pins_o[9] and the last is segment a of digit 0.
- R3: The outputs change only on the latch clock. After the start bit and all 34 payload bits, and before the final clock, they still hold the previous frame.
- R4: When `ser_en_n` is high, every bit shifted in is '0'. A whole frame clocked in with enable high leaves the outputs unchanged and does not disturb the frame that follows.
- R5: Enable does not reset the shift register. If enable is raised and lowered again mid-frame with no serial clocks in between, the frame still completes correctly.
- R6: Extra serial clocks with data '0' after a frame leave the outputs unchanged. The next '1' is taken as the start of a new frame.
- R7: On the latch clock the shift register clears to all zeros, including the bit shifted in on that clock.
- R8: Data is sampled at the serial clock rising edge. A change on `ser_data` while `ser_clk` is high has no effect.
- R9: A reset in the middle of a frame throws away the partial frame. The next full frame then decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data |
| ser_en_n | input | 1 | Active-low enable; when high, the shifted-in bit is forced to zero |
| digit_o | output | 24 | Three digit bytes, decimal point in bit 7, segments g..a in bits 6..0 |
| pins_o | output | 10 | Extra discrete output pins |

## Verification
The bench holds back the final clock of a frame and watches for an early update. A receiver that loads one clock too soon, or that uses a start-bit position one bit off, fails this test. Enable is exercised in two ways: a full frame is sent with enable high, and enable is toggled in the middle of a frame. A design that ignores enable would latch garbage. A design that resets on enable would lose the first half of the frame. Data is wobbled during the clock-high phase to expose sampling on the wrong edge. A reset in the middle of a frame is followed by a full frame, which shows whether leftover bits survive the reset and fire a latch inside the next frame. Zero-only trailing clocks and frames of all ones and all zeros cover the self-clear and the payload edges.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   // One digit byte: decimal point in the top bit, segments g..a below it.
   localparam int SEG_W = 8;
   typedef logic [SEG_W-1:0] seg_byte_t;

   function automatic int payload_bits(input int digits, input int pins);
      return digits * SEG_W + pins;
   endfunction
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
         else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
   end
endmodule

// File: rtl/sfr_rise_det.sv
module sfr_rise_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);
   logic prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end
   assign rise = lvl & ~prev;
endmodule

// File: rtl/sfr_shift_core.sv
module sfr_shift_core #(
   parameter int PW = 34
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          bit_in,
   output logic [PW:0]   sreg_o,
   output logic          fire_o,
   output logic [PW-1:0] word_o
);
   localparam int TOP = PW;
   logic [PW:0] sreg;

   // The start bit sits in the top cell; the next step pushes it out.
   assign fire_o = step & sreg[TOP];
   assign word_o = sreg[PW-1:0];
   assign sreg_o = sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sreg <= '0;
      else if (fire_o) sreg <= '0;
      else if (step)   sreg <= {sreg[PW-1:0], bit_in};
   end
endmodule

// File: rtl/sfr_out_latch.sv
module sfr_out_latch
   import sfr_pkg::*;
#(
   parameter int DIGITS = 3,
   parameter int NPINS = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [DIGITS*SEG_W+NPINS-1:0] word,
   output logic [DIGITS*SEG_W-1:0]   digits,
   output logic [NPINS-1:0]          pins
);
   localparam int DW = DIGITS * SEG_W;

   for (genvar k = 0; k < DIGITS; k++) begin : g_digit
      seg_byte_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q <= '0;
         else if (load) q <= word[k*SEG_W +: SEG_W];
      end
      assign digits[k*SEG_W +: SEG_W] = q;
   end

   logic [NPINS-1:0] pin_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pin_q <= '0;
      else if (load) pin_q <= word[DW +: NPINS];
   end
   assign pins = pin_q;
endmodule

// File: rtl/seg_frame_rx.sv
module seg_frame_rx
   import sfr_pkg::*;
#(
   parameter int DIGITS = 3,
   parameter int AUX_PINS = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ser_clk,
   input  logic                     ser_data,
   input  logic                     ser_en_n,
   output logic [DIGITS*SEG_W-1:0]  digit_o,
   output logic [AUX_PINS-1:0]      pins_o
);
   localparam int PW = payload_bits(DIGITS, AUX_PINS);

   if (DIGITS < 1) begin : g_bad_digits
      $error("seg_frame_rx: DIGITS must be at least 1");
   end
   if (AUX_PINS < 1) begin : g_bad_pins
      $error("seg_frame_rx: AUX_PINS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("seg_frame_rx: SYNC_STAGES must be at least 2");
   end

   logic sclk_q, dat_q, en_q;
   sfr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ser_en_n, ser_data, ser_clk}),
      .q({en_q, dat_q, sclk_q})
   );

   logic sclk_rise;
   sfr_rise_det i_rise (.clk(clk), .rst_n(rst_n), .lvl(sclk_q), .rise(sclk_rise));

   logic          bit_in;
   logic [PW:0]   sreg;
   logic          fire;
   logic [PW-1:0] word;
   assign bit_in = dat_q & ~en_q;

   sfr_shift_core #(.PW(PW)) i_core (
      .clk(clk), .rst_n(rst_n), .step(sclk_rise), .bit_in(bit_in),
      .sreg_o(sreg), .fire_o(fire), .word_o(word)
   );

   sfr_out_latch #(.DIGITS(DIGITS), .NPINS(AUX_PINS)) i_latch (
      .clk(clk), .rst_n(rst_n), .load(fire), .word(word),
      .digits(digit_o), .pins(pins_o)
   );
endmodule

// File: rtl/sfr_chk.sv
module sfr_chk #(
   parameter int PW = 34
) (
   input logic          clk,
   input logic          rst_n,
   input logic          step,
   input logic          gate_n,
   input logic          fire,
   input logic [PW:0]   sreg,
   input logic [PW-1:0] word,
   input logic [PW-1:0] outs
);
   assert_reset_zero_R1: assert property (@(posedge clk)
      !rst_n |=> (outs == '0));

   assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (outs == $past(word)));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(outs));

   assert_gate_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && gate_n) |=> !sreg[0]);

   assert_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (sreg == '0));
endmodule

bind seg_frame_rx sfr_chk #(.PW(PW)) i_chk (
   .clk(clk), .rst_n(rst_n), .step(sclk_rise), .gate_n(en_q),
   .fire(fire), .sreg(sreg), .word(word), .outs({pins_o, digit_o})
);

// File: tb/test_seg_frame_rx.sv
module test_seg_frame_rx;
   localparam int ND = 3;
   localparam int NP = 10;
   localparam int PW = ND * 8 + NP;
   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_en_n = 1'b1;
   logic [ND*8-1:0] digit_o;
   logic [NP-1:0]   pins_o;
   wire  [PW-1:0]   outs = {pins_o, digit_o};

   always #2 clk = ~clk;

   seg_frame_rx i_seg_frame_rx (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_en_n(ser_en_n), .digit_o(digit_o), .pins_o(pins_o)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [PW-1:0] exp_q[$];
   logic [PW-1:0] last_seen;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Scoreboard monitor: every output update must match the oldest expected word.
   always @(negedge clk) begin
      if (!rst_n) begin
         last_seen = outs;
      end else if (outs !== last_seen) begin
         if (exp_q.size() == 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R3 unexpected update: got %h expected %h", outs, last_seen);
         end else begin
            check("R2 scoreboard", outs, exp_q.pop_front());
         end
         last_seen = outs;
      end
   end

   task automatic send_bit(input logic b, input bit wobble);
      ser_data = b;
      tick(HALF);
      ser_clk = 1'b1;
      tick(3);
      if (wobble) ser_data = ~b;
      tick(HALF - 3);
      ser_clk = 1'b0;
   endtask

   task automatic open_frame();
      ser_en_n = 1'b0;
      tick(30);
   endtask

   task automatic send_span(input logic [PW-1:0] w, input int hi, input int lo, input bit wobble);
      for (int i = hi; i >= lo; i--) send_bit(w[i], wobble);
   endtask

   task automatic send_frame(input logic [PW-1:0] w, input bit wobble);
      send_bit(1'b1, 1'b0);
      send_span(w, PW - 1, 0, wobble);
      exp_q.push_back(w);
      send_bit(1'b0, 1'b0);
      tick(12);
   endtask

   initial begin
      tick(200000 - 10);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      tick(5);
      check("R1 reset outputs", outs, '0);
      rst_n = 1'b1;
      tick(5);

      // R2: a plain frame
      open_frame();
      send_frame(34'h1_A5C3_3C96, 1'b0);
      check("R2 frame A", outs, 34'h1_A5C3_3C96);

      // R3: nothing moves until the latch clock
      send_bit(1'b1, 1'b0);
      send_span(34'h2_0F0F_1E2D, PW - 1, 0, 1'b0);
      tick(20);
      check("R3 hold before latch clock", outs, 34'h1_A5C3_3C96);
      exp_q.push_back(34'h2_0F0F_1E2D);
      send_bit(1'b0, 1'b0);
      tick(12);
      check("R3 update on latch clock", outs, 34'h2_0F0F_1E2D);

      // R6 / R7: trailing zero clocks, then a back-to-back frame
      for (int i = 0; i < 12; i++) send_bit(1'b0, 1'b0);
      tick(10);
      check("R6 zero clocks keep outputs", outs, 34'h2_0F0F_1E2D);
      send_frame(34'h3_8001_0204, 1'b0);
      check("R7 next frame after clear", outs, 34'h3_8001_0204);

      // R4: whole frame with enable high is ignored
      ser_en_n = 1'b1;
      tick(10);
      send_bit(1'b1, 1'b0);
      send_span(34'h3_FFFF_FFFF, PW - 1, 0, 1'b0);
      send_bit(1'b1, 1'b0);
      tick(12);
      check("R4 disabled frame ignored", outs, 34'h3_8001_0204);
      open_frame();
      send_frame(34'h0_7F7F_7F7F, 1'b0);
      check("R4 frame after disabled one", outs, 34'h0_7F7F_7F7F);

      // R5: enable toggled mid-frame without clocks
      send_bit(1'b1, 1'b0);
      send_span(34'h1_1357_9BDF, PW - 1, 14, 1'b0);
      ser_en_n = 1'b1;
      tick(20);
      ser_en_n = 1'b0;
      tick(30);
      send_span(34'h1_1357_9BDF, 13, 0, 1'b0);
      exp_q.push_back(34'h1_1357_9BDF);
      send_bit(1'b0, 1'b0);
      tick(12);
      check("R5 enable toggle keeps register", outs, 34'h1_1357_9BDF);

      // R8: data wobbles while clock is high
      send_frame(34'h2_DEAD_BEEF, 1'b1);
      check("R8 rising edge sampling", outs, 34'h2_DEAD_BEEF);

      // Payload extremes
      send_frame(34'h3_FFFF_FFFF, 1'b0);
      check("R2 all ones", outs, 34'h3_FFFF_FFFF);
      send_frame(34'h0_0000_0000, 1'b0);
      check("R2 all zeros", outs, 34'h0_0000_0000);

      // R9: reset mid-frame discards partial bits
      send_frame(34'h0_CAFE_0001, 1'b0);
      send_bit(1'b1, 1'b0);
      send_span(34'h3_3333_3333, PW - 1, PW - 15, 1'b0);
      rst_n = 1'b0;
      tick(3);
      check("R9 reset clears outputs", outs, '0);
      check("R1 reset during run", outs, '0);
      rst_n = 1'b1;
      tick(5);
      send_frame(34'h0_CAFE_F00D, 1'b0);
      check("R9 frame after reset", outs, 34'h0_CAFE_F00D);

      check("R2 scoreboard drained", PW'(exp_q.size()), '0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule